// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog with a small byte-addressed register file. A prescaler turns the core clock into slow ticks, nominally 0.6 s each. Software picks a 6-bit start count, restarts the countdown by writing a key value to the reload offset, and can freeze or run the countdown through a halt bit in the control word.

The countdown expires in two stages. The first expiry sets a sticky first-stage flag, reloads the counter on its own and arms the second stage. It also raises a management interrupt if either of the two interrupt-enable bits is set. A second expiry with no reload in between sets a second-stage flag. If the reboot-enable input is high, it also sends a one-cycle system reset request and sets a boot flag. A reload returns the block to the first stage.

The status flags ignore the warm reset `rst`. Only `pwr_rst` or a write-one-to-clear access from software clears them. Read data is registered, so it appears one cycle after the address is presented.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset the control word reads 0x1000 (halted), the start count reads INIT_RST, the current count reads INIT_RST, status reads 0, the interrupt-enable word reads 0x0030, and `rst_req` and `mgmt_irq` are low.
- R2: A write to offset 0x01 with bits [5:0] of 4 or more stores the whole byte, and the byte reads back unchanged.
- R3: A write to offset 0x01 whose bits [5:0] are 0 to 3 leaves the stored start count unchanged. Bits [7:6] are still stored.
- R4: A write of 0x01 to offset 0x00 loads the counter from the start count and restarts the prescaler. Any other data written there has no effect. Reading offset 0x00 returns the current count.
- R5: While running, the count drops by one every TICK_DIV clock cycles.
- R6: While bit 12 of the control word at offset 0x08 is 1, the count does not change.
- R7: The first expiry comes start-count ticks after a reload. It sets status bit 1, reloads the counter and does not request a reset.
- R8: `mgmt_irq` is high while status bit 1 is set and at least one of bits 4 and 5 of the enable word at offset 0x0C is 1. With both bits 0 it stays low.
- R9: A second expiry with no reload in between sets status bit 10. When `reboot_en` is 1, it also sets bit 9 and gives exactly one cycle of `rst_req`.
- R10: With `reboot_en` at 0, a second expiry sets bit 10 but does not set bit 9 and does not assert `rst_req`.
- R11: A reload after the first expiry returns the block to the first stage, so the next expiry sets only bit 1.
- R12: Writing ones to status offset 0x04 clears bits 1, 9 and 10. If an expiry sets a bit in the same cycle, the set wins.
- R13: `rst` restores the control, start-count and enable registers but keeps the status flags. `pwr_rst` also clears the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous warm reset, active high; status is kept |
| pwr_rst | input | 1 | Synchronous power-good reset, active high; clears everything |
| wr_en | input | 1 | Write strobe for the register file |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data for `addr` |
| reboot_en | input | 1 | Allows the second expiry to request a system reset |
| rst_req | output | 1 | One-cycle system reset request |
| mgmt_irq | output | 1 | Management interrupt from the first expiry |

## Verification
The first-stage expiry can set status bit 1 on the same clock edge on which software writes one to clear that bit. The bench provokes this by working out the exact edge of the expiry from the reload edge, the start count and TICK_DIV, and placing the clear on that edge. The check passes if the flag still reads as set afterwards, and a later clear on an edge with no expiry removes it.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned CNT_W  = 6;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SPARE_W = BYTE_W - CNT_W;

  localparam logic [ADDR_W-1:0] OFF_RELOAD = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_INIT   = 4'h1;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_IRQEN  = 4'hC;

  localparam int unsigned B_FIRST  = 1;
  localparam int unsigned B_BOOT   = 9;
  localparam int unsigned B_SECOND = 10;
  localparam int unsigned B_HALT   = 12;
  localparam int unsigned B_IEN    = 4;

  localparam logic [BYTE_W-1:0] RELOAD_KEY = 8'h01;
  localparam logic [CNT_W-1:0]  MIN_INIT   = 6'd4;

  typedef struct packed {
    logic first;
    logic second;
  } wdt2_exp_t;
endpackage

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  assign tick = run && (pre == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre <= '0;
    end else if (run) begin
      pre <= tick ? '0 : pre + 1'b1;
    end
  end

  p_pre_range_r5: assert property (@(posedge clk) disable iff (rst)
    pre <= LAST);

  p_pre_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(pre));
endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter
  import wdt2_pkg::*;
#(
  parameter logic [CNT_W-1:0] INIT_RST = 6'd50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] init_val,
  output logic [CNT_W-1:0] cnt,
  output wdt2_exp_t        exp_ev
);
  logic stage2;
  logic hit;

  always_comb begin
    hit           = tick && !reload && (cnt < CNT_W'(2));
    exp_ev.first  = hit && !stage2;
    exp_ev.second = hit && stage2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= INIT_RST;
      stage2 <= 1'b0;
    end else if (reload) begin
      cnt    <= init_val;
      stage2 <= 1'b0;
    end else if (tick) begin
      if (cnt < CNT_W'(2)) begin
        cnt    <= init_val;
        stage2 <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  p_reload_load_r4: assert property (@(posedge clk) disable iff (rst)
    reload |=> (cnt == $past(init_val)));

  p_step_down_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !reload && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));

  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
    (!tick && !reload) |=> $stable(cnt));

  p_second_after_first_r9: assert property (@(posedge clk) disable iff (rst)
    exp_ev.first |=> !exp_ev.first);
endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
  import wdt2_pkg::*;
#(
  parameter logic [CNT_W-1:0] INIT_RST = 6'd50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              reboot_en,
  input  logic [CNT_W-1:0]  cnt,
  input  wdt2_exp_t         exp_ev,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  init_val,
  output logic              halt,
  output logic              reload,
  output logic              rst_req,
  output logic              mgmt_irq
);
  logic               warm;
  logic [SPARE_W-1:0] spare;
  logic [1:0]         irq_en;
  logic               sts_first;
  logic               sts_second;
  logic               sts_boot;
  logic               wr_init;
  logic               wr_stat;
  logic               wr_ctrl;
  logic               wr_ien;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_wdata;

  assign warm    = rst || pwr_rst;
  assign wr_init = wr_en && (addr == OFF_INIT);
  assign wr_stat = wr_en && (addr == OFF_STATUS);
  assign wr_ctrl = wr_en && (addr == OFF_CTRL);
  assign wr_ien  = wr_en && (addr == OFF_IRQEN);
  assign reload  = wr_en && (addr == OFF_RELOAD) && (wdata[BYTE_W-1:0] == RELOAD_KEY);
  assign unused_wdata = ^{wdata[15:13], wdata[11], wdata[8]};

  always_ff @(posedge clk) begin
    if (warm) begin
      init_val <= INIT_RST;
      spare    <= '0;
      halt     <= 1'b1;
      irq_en   <= 2'b11;
    end else begin
      if (wr_init) begin
        spare <= wdata[BYTE_W-1:CNT_W];
        if (wdata[CNT_W-1:0] >= MIN_INIT) begin
          init_val <= wdata[CNT_W-1:0];
        end
      end
      if (wr_ctrl) begin
        halt <= wdata[B_HALT];
      end
      if (wr_ien) begin
        irq_en <= wdata[B_IEN+1:B_IEN];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pwr_rst) begin
      sts_first  <= 1'b0;
      sts_second <= 1'b0;
      sts_boot   <= 1'b0;
    end else begin
      sts_first  <= exp_ev.first  || (sts_first  && !(wr_stat && wdata[B_FIRST]));
      sts_second <= exp_ev.second || (sts_second && !(wr_stat && wdata[B_SECOND]));
      sts_boot   <= (exp_ev.second && reboot_en) ||
                    (sts_boot && !(wr_stat && wdata[B_BOOT]));
    end
  end

  always_ff @(posedge clk) begin
    if (warm) begin
      rst_req <= 1'b0;
    end else begin
      rst_req <= exp_ev.second && reboot_en;
    end
  end

  assign mgmt_irq = sts_first && (|irq_en);

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      OFF_RELOAD: rd_mux[CNT_W-1:0]  = cnt;
      OFF_INIT:   rd_mux[BYTE_W-1:0] = {spare, init_val};
      OFF_STATUS: begin
        rd_mux[B_FIRST]  = sts_first;
        rd_mux[B_BOOT]   = sts_boot;
        rd_mux[B_SECOND] = sts_second;
      end
      OFF_CTRL:   rd_mux[B_HALT] = halt;
      OFF_IRQEN:  rd_mux[B_IEN+1:B_IEN] = irq_en;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (warm) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_mux;
    end
  end

  p_init_valid_r3: assert property (@(posedge clk) disable iff (warm)
    init_val >= MIN_INIT);

  p_first_sets_r7: assert property (@(posedge clk) disable iff (warm)
    exp_ev.first |=> sts_first);

  p_rst_single_r9: assert property (@(posedge clk) disable iff (warm)
    rst_req |=> !rst_req);

  p_rst_boot_r9: assert property (@(posedge clk) disable iff (warm)
    rst_req |-> sts_boot);

  p_rst_gated_r10: assert property (@(posedge clk) disable iff (warm)
    rst_req |-> $past(reboot_en));

  p_w1c_first_r12: assert property (@(posedge clk) disable iff (warm)
    (wr_stat && wdata[B_FIRST] && !exp_ev.first) |=> !sts_first);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
  import wdt2_pkg::*;
#(
  parameter int unsigned      TICK_DIV = 75_000_000,
  parameter logic [CNT_W-1:0] INIT_RST = 6'd50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic              reboot_en,
  output logic              rst_req,
  output logic              mgmt_irq
);
  logic             warm;
  logic             tick;
  logic             halt;
  logic             reload;
  logic [CNT_W-1:0] init_val;
  logic [CNT_W-1:0] cnt;
  wdt2_exp_t        exp_ev;

  assign warm = rst || pwr_rst;

  wdt2_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk  (clk),
    .rst  (warm),
    .clr  (reload),
    .run  (!halt),
    .tick (tick)
  );

  wdt2_counter #(.INIT_RST(INIT_RST)) u_cnt (
    .clk      (clk),
    .rst      (warm),
    .tick     (tick),
    .reload   (reload),
    .init_val (init_val),
    .cnt      (cnt),
    .exp_ev   (exp_ev)
  );

  wdt2_regs #(.INIT_RST(INIT_RST)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .pwr_rst   (pwr_rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .reboot_en (reboot_en),
    .cnt       (cnt),
    .exp_ev    (exp_ev),
    .rd_data   (rd_data),
    .init_val  (init_val),
    .halt      (halt),
    .reload    (reload),
    .rst_req   (rst_req),
    .mgmt_irq  (mgmt_irq)
  );

  p_halt_no_expiry_r6: assert property (@(posedge clk) disable iff (warm)
    halt |-> !(exp_ev.first || exp_ev.second));
endmodule

// File: tb/wdt_two_stage_tb_top.sv
module wdt_two_stage_tb_top;
  localparam int unsigned TD = 4;
  localparam int unsigned ST = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rd_data;
  logic        reboot_en = 1'b1;
  logic        rst_req;
  logic        mgmt_irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int rst_seen = 0;
  int e0;
  int e1;
  int rs;
  logic [15:0] v;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_req) rst_seen <= rst_seen + 1;

  wdt_two_stage #(.TICK_DIV(TD), .INIT_RST(6'd50)) dut_i (
    .clk(clk), .rst(rst), .pwr_rst(pwr_rst), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .reboot_en(reboot_en),
    .rst_req(rst_req), .mgmt_irq(mgmt_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    @(posedge clk); #1;
    d = rd_data;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic t_reset;
    rd(4'h8, v); chk("R1 ctrl", v, 16'h1000);
    rd(4'h1, v); chk("R1 init", v, 16'h0032);
    rd(4'h0, v); chk("R1 count", v, 16'h0032);
    rd(4'h4, v); chk("R1 status", v, 16'h0000);
    rd(4'hC, v); chk("R1 irq enable", v, 16'h0030);
    chk("R1 rst_req", {15'h0, rst_req}, 16'h0);
    chk("R1 mgmt_irq", {15'h0, mgmt_irq}, 16'h0);
  endtask

  task automatic t_init;
    wr(4'h1, 16'h00C5);
    rd(4'h1, v); chk("R2 init readback", v, 16'h00C5);
    wr(4'h1, 16'h0002);
    rd(4'h1, v); chk("R3 invalid start ignored", v, 16'h0005);
    wr(4'h1, 16'h0003);
    rd(4'h1, v); chk("R3 invalid start 3 ignored", v, 16'h0005);
  endtask

  task automatic t_reload;
    wr(4'h0, 16'h0002);
    rd(4'h0, v); chk("R4 wrong key no reload", v, 16'h0032);
    wr(4'h0, 16'h0001);
    rd(4'h0, v); chk("R4 reload", v, 16'h0005);
  endtask

  task automatic t_count_halt;
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0001); e0 = cyc;
    wait_until(e0 + TD);     rd(4'h0, v); chk("R5 after one tick", v, 16'd4);
    wait_until(e0 + 2 * TD); rd(4'h0, v); chk("R5 after two ticks", v, 16'd3);
    wr(4'h8, 16'h1000);
    wait_until(e0 + 30);     rd(4'h0, v); chk("R6 halted count", v, 16'd3);
  endtask

  task automatic t_expiry;
    reboot_en = 1'b1;
    rs = rst_seen;
    wr(4'h8, 16'h0000);
    wr(4'h0, 16'h0001); e0 = cyc;
    wait_until(e0 + ST * TD - 1);
    rd(4'h4, v); chk("R7 status before expiry", v, 16'h0000);
    rd(4'h4, v); chk("R7 first flag", v, 16'h0002);
    chk("R7 no reset at first", {15'h0, rst_req}, 16'h0);
    chk("R8 irq raised", {15'h0, mgmt_irq}, 16'h1);
    rd(4'h0, v); chk("R7 auto reload", v, 16'd5);
    wait_until(e0 + 2 * ST * TD - 1);
    chk("R9 no reset before second", {15'h0, rst_req}, 16'h0);
    @(posedge clk); #1;
    chk("R9 reset pulse", {15'h0, rst_req}, 16'h1);
    @(posedge clk); #1;
    chk("R9 reset one cycle", {15'h0, rst_req}, 16'h0);
    rd(4'h4, v); chk("R9 status second and boot", v, 16'h0602);
    chk("R9 single pulse count", 16'(rst_seen - rs), 16'd1);
  endtask

  task automatic t_w1c_collide;
    wr(4'h4, 16'h0602);
    rd(4'h4, v); chk("R12 clear all", v, 16'h0000);
    chk("R12 irq dropped", {15'h0, mgmt_irq}, 16'h0);
    wr(4'h0, 16'h0001); e0 = cyc;
    wait_until(e0 + ST * TD - 1);
    wr(4'h4, 16'h0002);
    rd(4'h4, v); chk("R12 set wins over clear", v, 16'h0002);
    wr(4'h4, 16'h0002);
    rd(4'h4, v); chk("R12 later clear", v, 16'h0000);
  endtask

  task automatic t_noirq;
    wr(4'hC, 16'h0000);
    wr(4'h0, 16'h0001); e0 = cyc;
    wait_until(e0 + ST * TD);
    rd(4'h4, v); chk("R8 flag without irq", v, 16'h0002);
    chk("R8 irq masked", {15'h0, mgmt_irq}, 16'h0);
    wr(4'hC, 16'h0010);
    chk("R8 irq with one enable", {15'h0, mgmt_irq}, 16'h1);
    wr(4'h4, 16'h0002);
  endtask

  task automatic t_noreboot;
    reboot_en = 1'b0;
    rs = rst_seen;
    wr(4'h0, 16'h0001); e0 = cyc;
    wait_until(e0 + 2 * ST * TD + 1);
    rd(4'h4, v); chk("R10 second flag only", v, 16'h0402);
    chk("R10 no reset", 16'(rst_seen - rs), 16'd0);
    wr(4'h4, 16'h0602);
  endtask

  task automatic t_stage_back;
    reboot_en = 1'b1;
    rs = rst_seen;
    wr(4'h0, 16'h0001); e0 = cyc;
    wait_until(e0 + ST * TD + 3);
    rd(4'h4, v); chk("R11 first expiry seen", v, 16'h0002);
    wr(4'h0, 16'h0001); e1 = cyc;
    wr(4'h4, 16'h0002);
    wait_until(e1 + ST * TD);
    rd(4'h4, v); chk("R11 back to first stage", v, 16'h0002);
    chk("R11 no reset", 16'(rst_seen - rs), 16'd0);
    wr(4'h8, 16'h1000);
  endtask

  task automatic t_resets;
    rst = 1'b1; @(posedge clk); #1; rst = 1'b0;
    rd(4'h4, v); chk("R13 status kept on warm reset", v, 16'h0002);
    rd(4'h8, v); chk("R13 ctrl restored", v, 16'h1000);
    rd(4'h1, v); chk("R13 init restored", v, 16'h0032);
    pwr_rst = 1'b1; @(posedge clk); #1; pwr_rst = 1'b0;
    rd(4'h4, v); chk("R13 status cleared by power reset", v, 16'h0000);
  endtask

  initial begin
    @(posedge clk); #1;
    repeat (3) begin @(posedge clk); #1; end
    rst = 1'b0; pwr_rst = 1'b0;
    t_reset;
    t_init;
    t_reload;
    t_count_halt;
    t_expiry;
    t_w1c_collide;
    t_noirq;
    t_noreboot;
    t_stage_back;
    t_resets;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule